// File: doc/BRIEF.md
# Selectable-Precision Taint Tracking Gate Array

This block is a purely combinational shadow datapath for information flow tracking at the gate level. It holds a row of two-input bitwise gates. The first lanes are AND gates and the remaining lanes are OR gates. Each lane carries two data bits and one taint bit for each operand. Each lane computes its data result together with a taint bit that says whether the result can depend on a tainted operand.

A 3-bit code for each lane picks how that lane computes its taint. The codes run from an exact equation, through cheaper but still conservative approximations, down to forcing values that are not sound. A parameter limits the menu to the first four versions or opens all eight.

A separate cost output adds up an area estimate for the taint logic that the current codes would need. The estimate is either a weighted gate count or a count of lanes running below full precision. An outside search can use this to trade precision against size.

Per-lane flags mark an operand as a constant. A flagged operand's taint is replaced by a fixed configured value. Parameters can drop the cost figure (held at zero) and the data results (held at zero) when only the taint view is wanted.

Top module: `taint_track_array`

## Requirements
- R1: With code 0 (exact), an AND lane gives yT = (a & bT) | (b & aT) | (aT & bT).
- R2: With code 0, an OR lane gives yT = (~a & bT) | (~b & aT) | (aT & bT).
- R3: Code 1 gives yT = aT | (pa & bT) and code 2 gives yT = bT | (pb & aT). Here pa and pb are a and b on AND lanes, and ~a and ~b on OR lanes.
- R4: Code 3 gives yT = aT | bT on both lane kinds.
- R5: When EXTENDED=1, codes 4, 5, 6 and 7 give yT = aT, bT, 1 and 0 respectively.
- R6: When EXTENDED=0, codes 4 to 7 behave exactly like code 3.
- R7: For codes 0 to 3, yT is never 0 when the exact equation gives 1.
- R8: When a lane's constA (or constB) flag is 1, that operand's taint is taken as CONST_TAINTED (default 0) and the aT (or bT) input is ignored.
- R9: When KEEP_DATA=1, bit i of y is a&b on AND lanes (i < NUM_AND) and a|b on OR lanes. When KEEP_DATA=0, y is all zero.
- R10: When COST_MODE=2, cost is the sum over lanes of 5, 2, 2, 1, 0, 0, 0, 0 for effective codes 0 to 7. Its width holds 5·LANES.
- R11: When COST_MODE=1, cost is the number of lanes whose effective code is non-zero. In base mode, codes 4 to 7 count as code 3.
- R12: When COST_MODE=0, cost is constantly zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a | input | LANES | Operand A data bits, one per lane |
| b | input | LANES | Operand B data bits, one per lane |
| aT | input | LANES | Operand A taint bits |
| bT | input | LANES | Operand B taint bits |
| constA | input | LANES | Marks operand A of a lane as a constant |
| constB | input | LANES | Marks operand B of a lane as a constant |
| sel | input | 3·LANES | Taint version code, lane i in bits [3i+2:3i] |
| y | output | LANES | Data results |
| yT | output | LANES | Taint results |
| cost | output | clog2(5·LANES+1) | Area estimate of the selected taint logic |

## Verification
The embedded assertions are immediate checks on settled combinational values. They rely on every input being a defined 0 or 1, with no X or Z, whenever they are evaluated. They accept any 3-bit code and any combination of constant flags. The bench starts every input at zero and only ever drives full binary values. It changes the inputs once per clock, just after the rising edge, and reads outputs at the falling edge. An exhaustive sweep of the four operand bits under all eight codes is followed by pseudo-random lanes that mix codes and constant flags. Three configurations run side by side, so both menu sizes and all three cost modes are covered.

// File: rtl/taint_track_pkg.sv
package taint_track_pkg;

  // Taint version codes; the numeric order is the select encoding.
  typedef enum logic [2:0] {
    VER_EXACT   = 3'd0,
    VER_A_BIAS  = 3'd1,
    VER_B_BIAS  = 3'd2,
    VER_ALL_OR  = 3'd3,
    VER_A_ONLY  = 3'd4,
    VER_B_ONLY  = 3'd5,
    VER_ONE     = 3'd6,
    VER_ZERO    = 3'd7
  } taintVerE;

  localparam int VER_CODE_W = 3;
  localparam int MAX_VER_COST = 5;

  // One-hot strobes from control to a lane datapath.
  typedef struct packed {
    logic exact;
    logic aBias;
    logic bBias;
    logic allOr;
    logic aOnly;
    logic bOnly;
    logic forceOne;
    logic forceZero;
  } verStrobeT;

  // Rough gate count of each version's taint logic.
  function automatic logic [2:0] verCost(input taintVerE ver);
    logic [2:0] c;
    unique case (ver)
      VER_EXACT:  c = 3'd5;
      VER_A_BIAS: c = 3'd2;
      VER_B_BIAS: c = 3'd2;
      VER_ALL_OR: c = 3'd1;
      default:    c = 3'd0;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/taint_sel_ctrl.sv
module taint_sel_ctrl
  import taint_track_pkg::*;
#(
  parameter int LANES    = 4,
  parameter bit EXTENDED = 1'b1,
  localparam int SEL_W   = LANES * VER_CODE_W
) (
  input  logic                  [SEL_W-1:0] selFlat,
  output logic                  [SEL_W-1:0] effSelFlat,
  output verStrobeT             [LANES-1:0] strobes
);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [VER_CODE_W-1:0] rawSel;
    logic [VER_CODE_W-1:0] effSel;
    verStrobeT laneStb;

    assign rawSel = selFlat[i*VER_CODE_W +: VER_CODE_W];

    if (EXTENDED) begin : g_ext
      assign effSel = rawSel;
    end else begin : g_base
      assign effSel = (rawSel > 3'd3) ? 3'd3 : rawSel;
    end

    always_comb begin
      laneStb = '0;
      case (taintVerE'(effSel))
        VER_EXACT:  laneStb.exact     = 1'b1;
        VER_A_BIAS: laneStb.aBias     = 1'b1;
        VER_B_BIAS: laneStb.bBias     = 1'b1;
        VER_ALL_OR: laneStb.allOr     = 1'b1;
        VER_A_ONLY: laneStb.aOnly     = 1'b1;
        VER_B_ONLY: laneStb.bOnly     = 1'b1;
        VER_ONE:    laneStb.forceOne  = 1'b1;
        default:    laneStb.forceZero = 1'b1;
      endcase
    end

    assign effSelFlat[i*VER_CODE_W +: VER_CODE_W] = effSel;
    assign strobes[i] = laneStb;

    always_comb begin
      // R5
      strobe_onehot_chk: assert ($onehot(laneStb));
      // R6
      if (!EXTENDED) begin
        base_limit_chk: assert (!(laneStb.aOnly | laneStb.bOnly | laneStb.forceOne | laneStb.forceZero));
      end
    end
  end

endmodule

// File: rtl/taint_lane_dp.sv
module taint_lane_dp
  import taint_track_pkg::*;
#(
  parameter bit IS_OR         = 1'b0,
  parameter bit CONST_TAINTED = 1'b0,
  parameter bit KEEP_DATA     = 1'b1
) (
  input  logic      a,
  input  logic      b,
  input  logic      aT,
  input  logic      bT,
  input  logic      constA,
  input  logic      constB,
  input  verStrobeT stb,
  output logic      y,
  output logic      yT
);

  logic atEff, btEff;
  logic passA, passB;
  logic tExact, tABias, tBBias, tAllOr;

  always_comb begin
    atEff  = constA ? CONST_TAINTED : aT;
    btEff  = constB ? CONST_TAINTED : bT;
    // An operand's taint reaches the output when the other operand does not dominate.
    passA  = IS_OR ? ~a : a;
    passB  = IS_OR ? ~b : b;
    tExact = (passA & btEff) | (passB & atEff) | (atEff & btEff);
    tABias = atEff | (passA & btEff);
    tBBias = btEff | (passB & atEff);
    tAllOr = atEff | btEff;
    yT = (stb.exact & tExact) | (stb.aBias & tABias) | (stb.bBias & tBBias)
       | (stb.allOr & tAllOr) | (stb.aOnly & atEff) | (stb.bOnly & btEff)
       | stb.forceOne;
  end

  if (KEEP_DATA) begin : g_data
    assign y = IS_OR ? (a | b) : (a & b);
  end else begin : g_nodata
    assign y = 1'b0;
  end

  always_comb begin
    // R7
    if (stb.exact | stb.aBias | stb.bBias | stb.allOr) begin
      conservative_chk: assert (!tExact || yT);
    end
    // R4
    if (!atEff && !btEff && !stb.forceOne) begin
      untainted_quiet_chk: assert (!yT);
    end
  end

endmodule

// File: rtl/taint_cost_sum.sv
module taint_cost_sum
  import taint_track_pkg::*;
#(
  parameter int LANES     = 4,
  parameter int COST_MODE = 2,
  parameter int COST_W    = 5,
  localparam int SEL_W    = LANES * VER_CODE_W
) (
  input  logic [SEL_W-1:0]  effSelFlat,
  output logic [COST_W-1:0] cost
);

  if (COST_MODE == 2) begin : g_full
    always_comb begin
      cost = '0;
      for (int i = 0; i < LANES; i++) begin
        cost = cost + COST_W'(verCost(taintVerE'(effSelFlat[i*VER_CODE_W +: VER_CODE_W])));
      end
    end
  end else if (COST_MODE == 1) begin : g_simple
    always_comb begin
      cost = '0;
      for (int i = 0; i < LANES; i++) begin
        cost = cost + COST_W'(effSelFlat[i*VER_CODE_W +: VER_CODE_W] != '0);
      end
    end
  end else begin : g_none
    assign cost = '0;
  end

  always_comb begin
    // R10
    cost_bound_chk: assert (32'(cost) <= MAX_VER_COST * LANES);
  end

endmodule

// File: rtl/taint_track_array.sv
module taint_track_array
  import taint_track_pkg::*;
#(
  parameter int NUM_AND       = 2,
  parameter int NUM_OR        = 2,
  parameter bit EXTENDED      = 1'b1,
  parameter int COST_MODE     = 2,
  parameter bit CONST_TAINTED = 1'b0,
  parameter bit KEEP_DATA     = 1'b1,
  localparam int LANES        = NUM_AND + NUM_OR,
  localparam int SEL_W        = LANES * VER_CODE_W,
  localparam int COST_W       = $clog2(MAX_VER_COST * LANES + 1)
) (
  input  logic [LANES-1:0]  a,
  input  logic [LANES-1:0]  b,
  input  logic [LANES-1:0]  aT,
  input  logic [LANES-1:0]  bT,
  input  logic [LANES-1:0]  constA,
  input  logic [LANES-1:0]  constB,
  input  logic [SEL_W-1:0]  sel,
  output logic [LANES-1:0]  y,
  output logic [LANES-1:0]  yT,
  output logic [COST_W-1:0] cost
);

  verStrobeT [LANES-1:0] strobes;
  logic [SEL_W-1:0] effSel;

  taint_sel_ctrl #(.LANES(LANES), .EXTENDED(EXTENDED)) u_ctrl (
    .selFlat(sel), .effSelFlat(effSel), .strobes(strobes)
  );

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    taint_lane_dp #(
      .IS_OR(i >= NUM_AND), .CONST_TAINTED(CONST_TAINTED), .KEEP_DATA(KEEP_DATA)
    ) u_dp (
      .a(a[i]), .b(b[i]), .aT(aT[i]), .bT(bT[i]),
      .constA(constA[i]), .constB(constB[i]),
      .stb(strobes[i]), .y(y[i]), .yT(yT[i])
    );
  end

  taint_cost_sum #(.LANES(LANES), .COST_MODE(COST_MODE), .COST_W(COST_W)) u_cost (
    .effSelFlat(effSel), .cost(cost)
  );

endmodule

// File: tb/taint_track_array_bench.sv
module taint_track_array_bench;

  localparam int CLK_PERIOD = 10;
  localparam int LN = 4;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [LN-1:0] a = '0, b = '0, aT = '0, bT = '0, cA = '0, cB = '0;
  logic [3*LN-1:0] sel = '0;

  logic [LN-1:0] mY, mYT, bY, bYT;
  logic [4:0] mCost, bCost;
  logic [1:0] nY, nYT;
  logic [3:0] nCost;

  // Main: extended menu, full cost, constants untainted, data kept.
  taint_track_array u_taint_track_array (
    .a(a), .b(b), .aT(aT), .bT(bT), .constA(cA), .constB(cB), .sel(sel),
    .y(mY), .yT(mYT), .cost(mCost));

  // Base menu, simple cost, constants tainted, data dropped.
  taint_track_array #(.EXTENDED(1'b0), .COST_MODE(1), .CONST_TAINTED(1'b1), .KEEP_DATA(1'b0))
    u_taint_track_array_base (
    .a(a), .b(b), .aT(aT), .bT(bT), .constA(cA), .constB(cB), .sel(sel),
    .y(bY), .yT(bYT), .cost(bCost));

  // Two lanes (one AND, one OR), no cost output.
  taint_track_array #(.NUM_AND(1), .NUM_OR(1), .COST_MODE(0)) u_taint_track_array_nocost (
    .a(a[1:0]), .b(b[1:0]), .aT(aT[1:0]), .bT(bT[1:0]), .constA(cA[1:0]), .constB(cB[1:0]),
    .sel(sel[5:0]), .y(nY), .yT(nYT), .cost(nCost));

  typedef struct {
    logic [LN-1:0] y, yT, exact, bY, bYT;
    logic [4:0] cost, bCost;
    logic [1:0] nY, nYT;
    logic [3:0] nCost;
    logic [3*LN-1:0] sel;
    logic [LN-1:0] cA, cB;
  } expT;

  expT expQ[$];
  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  function automatic logic refT(bit isOr, bit ext, logic [2:0] s, logic av, logic bv, logic at, logic bt);
    logic pa, pb;
    pa = isOr ? ~av : av;
    pb = isOr ? ~bv : bv;
    if (!ext && s > 3'd3) s = 3'd3;
    case (s)
      3'd0: return (pa & bt) | (pb & at) | (at & bt);
      3'd1: return at | (pa & bt);
      3'd2: return bt | (pb & at);
      3'd3: return at | bt;
      3'd4: return at;
      3'd5: return bt;
      3'd6: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic int refCost(bit ext, int mode, logic [2:0] s);
    if (!ext && s > 3'd3) s = 3'd3;
    if (mode == 0) return 0;
    if (mode == 1) return (s != 3'd0) ? 1 : 0;
    case (s)
      3'd0: return 5;
      3'd1, 3'd2: return 2;
      3'd3: return 1;
      default: return 0;
    endcase
  endfunction

  function automatic string reqOf(bit isOr, bit ext, logic [2:0] s, bit isConst);
    if (isConst) return "R8";
    if (!ext && s > 3'd3) return "R6";
    case (s)
      3'd0: return isOr ? "R2" : "R1";
      3'd1, 3'd2: return "R3";
      3'd3: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic check(string req, string what, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Driver: apply one vector and push its expected results.
  task automatic drive(logic [LN-1:0] va, vb, vat, vbt, vca, vcb, logic [3*LN-1:0] vs);
    expT e;
    int mc, bc;
    @(posedge clk);
    #1;
    a = va; b = vb; aT = vat; bT = vbt; cA = vca; cB = vcb; sel = vs;
    mc = 0; bc = 0;
    e.sel = vs; e.cA = vca; e.cB = vcb;
    for (int i = 0; i < LN; i++) begin
      bit isOr;
      logic [2:0] s;
      logic at0, bt0, at1, bt1;
      isOr = (i >= 2);
      s = vs[i*3 +: 3];
      at0 = vca[i] ? 1'b0 : vat[i];
      bt0 = vcb[i] ? 1'b0 : vbt[i];
      at1 = vca[i] ? 1'b1 : vat[i];
      bt1 = vcb[i] ? 1'b1 : vbt[i];
      e.yT[i]    = refT(isOr, 1'b1, s, va[i], vb[i], at0, bt0);
      e.exact[i] = refT(isOr, 1'b1, 3'd0, va[i], vb[i], at0, bt0);
      e.y[i]     = isOr ? (va[i] | vb[i]) : (va[i] & vb[i]);
      e.bYT[i]   = refT(isOr, 1'b0, s, va[i], vb[i], at1, bt1);
      e.bY[i]    = 1'b0;
      mc += refCost(1'b1, 2, s);
      bc += refCost(1'b0, 1, s);
    end
    for (int i = 0; i < 2; i++) begin
      bit isOr;
      isOr = (i >= 1);
      e.nYT[i] = refT(isOr, 1'b1, vs[i*3 +: 3], va[i], vb[i],
                      vca[i] ? 1'b0 : vat[i], vcb[i] ? 1'b0 : vbt[i]);
      e.nY[i]  = isOr ? (va[i] | vb[i]) : (va[i] & vb[i]);
    end
    e.cost = 5'(mc);
    e.bCost = 5'(bc);
    e.nCost = 4'd0;
    expQ.push_back(e);
  endtask

  // Monitor: compare settled outputs at the falling edge.
  always @(negedge clk) begin
    if (expQ.size() > 0) begin
      expT e;
      e = expQ.pop_front();
      for (int i = 0; i < LN; i++) begin
        bit isOr;
        logic [2:0] s;
        isOr = (i >= 2);
        s = e.sel[i*3 +: 3];
        check(reqOf(isOr, 1'b1, s, e.cA[i] | e.cB[i]), $sformatf("main yT lane %0d", i), mYT[i], e.yT[i]);
        check(reqOf(isOr, 1'b0, s, e.cA[i] | e.cB[i]), $sformatf("base yT lane %0d", i), bYT[i], e.bYT[i]);
        // R7: reduced versions stay conservative
        if (s <= 3'd3 && e.exact[i]) check("R7", $sformatf("conservative lane %0d", i), mYT[i], 1);
      end
      check("R9", "main y", mY, e.y);
      check("R9", "base y dropped", bY, e.bY);
      check("R10", "full cost", mCost, e.cost);
      check("R11", "simple cost", bCost, e.bCost);
      check("R12", "no cost", nCost, e.nCost);
      check("R2", "two-lane yT", nYT, e.nYT);
      check("R9", "two-lane y", nY, e.nY);
    end
  end

  initial begin
    // Idle state: all inputs zero (exact, no taint).
    drive('0, '0, '0, '0, '0, '0, '0);
    // Exhaustive sweep of the operand bits under each code, all lanes alike.
    for (int s = 0; s < 8; s++) begin
      for (int c = 0; c < 16; c++) begin
        logic [2:0] s3;
        s3 = 3'(s);
        drive({LN{c[3]}}, {LN{c[2]}}, {LN{c[1]}}, {LN{c[0]}}, '0, '0, {LN{s3}});
      end
    end
    // R8: constant flags override taint inputs.
    drive('1, '1, '1, '1, '1, '0, '0);
    drive('1, '1, '1, '1, '0, '1, '0);
    drive('0, '1, '0, '0, '1, '1, {LN{3'd3}});
    // R10/R11 extremes: all exact, all zero-forcing.
    drive('0, '0, '0, '0, '0, '0, {LN{3'd0}});
    drive('0, '0, '0, '0, '0, '0, {LN{3'd7}});
    // Mixed random lanes.
    for (int k = 0; k < 300; k++) begin
      logic [LN-1:0] ra, rb, rat, rbt, rca, rcb;
      logic [3*LN-1:0] rs;
      ra = LN'($urandom); rb = LN'($urandom); rat = LN'($urandom); rbt = LN'($urandom);
      rca = LN'($urandom) & LN'($urandom);
      rcb = LN'($urandom) & LN'($urandom);
      rs = (3*LN)'($urandom);
      drive(ra, rb, rat, rbt, rca, rcb, rs);
    end
    repeat (3) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      done = 1'b1;
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule